// File: doc/BRIEF.md
# Compressed Mode Length Sequencer

This block sits at the front of an instruction decode stage. It keeps track of whether the instruction stream is currently in standard 32-bit mode or in one of the compressed sub-modes. Each cycle it looks at a window of at least 32 bits. The window starts at the halfword the program counter points to. From that window and the current mode, the block reports three results: how many bytes the fetch unit must advance (2 or 4), the decode class of the instruction, and the mode that applies to the following instruction.

The length cannot be read from a fixed pair of length bits. The halfword's bit 0 and bit 15 mean different things depending on the sub-mode the stream is in, so the mode register supplies the context that decides the length. Opcode decode, immediate extraction and fetch alignment are handled elsewhere.

The window arrives on a valid/ready input and the decode result leaves on a valid/ready output. The two are combinationally coupled with no storage at the edge, so back-pressure passes straight through: `in_ready_o` follows `out_ready_i` and `out_valid_o` follows `in_valid_i`. A window counts as consumed, and the mode advances, only in a cycle where `in_valid_i` and `out_ready_i` are both high. While the window is held, the result stays a pure function of the window and the current mode.

Top module: `cmlen_top`

## Requirements
- R1: An active-low reset (`rst_n`) puts the current mode into standard (code 0). Mode codes are: 0 = standard, 1 = compressed-10, 2 = compressed-16, 3 = one-standard-then-compressed. Class codes are: 0 = standard, 1 = compressed-10, 2 = compressed-16, 3 = immediate form, 4 = alternate.
- R2: In standard mode, a halfword whose extension field (bits 14:10) differs from the marker (default 5'b10110) decodes as class 0 with 4 bytes, and the next mode is standard.
- R3: In standard mode, a halfword whose bits 14:10 equal the marker decodes as class 1 with 2 bytes, and the next mode is compressed-10.
- R4: In compressed-10 mode, every halfword decodes as class 1 with 2 bytes, whatever bits 14:10 hold. If bit 15 is 1 the next mode is compressed-16; if bit 15 is 0 it is standard.
- R5: In compressed-16 mode, a halfword with bit 0 = 1 and bit 15 = 1 decodes as class 3 with 2 bytes, and the next mode is compressed-16. This rule takes priority over R6.
- R6: In compressed-16 mode, a halfword with bit 0 = 1, bit 15 = 0 and a major field (bits 3:1) of 3'b010 decodes as class 4 with 2 bytes.
- R7: In compressed-16 mode, every other halfword decodes as class 2 with 2 bytes. In every compressed-16 case, the next mode is one-standard if bit 15 is 0 and compressed-16 if bit 15 is 1.
- R8: In one-standard mode, the instruction decodes as class 0 with 4 bytes, even if it carries the marker, and the next mode is compressed-16.
- R9: The current mode takes the reported next mode only on a rising edge where `in_valid_i` and `out_ready_i` are both high. Otherwise it holds. `in_ready_o` equals `out_ready_i` and `out_valid_o` equals `in_valid_i`.
- R10: `flush_i` high at a rising edge sets the current mode to standard, overriding any handshake in the same cycle.
- R11: Window bits above bit 15 have no effect on any decode result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush_i | input | 1 | Redirect or flush; returns the mode to standard |
| in_valid_i | input | 1 | Window valid |
| in_ready_o | output | 1 | Window accepted (follows out_ready_i) |
| in_win_i | input | WIN_W | Fetch window, bit 0 = first bit of current halfword |
| out_valid_o | output | 1 | Decode result valid |
| out_ready_i | input | 1 | Downstream accepts the result |
| out_bytes_o | output | 3 | PC advance in bytes, 2 or 4 |
| out_class_o | output | 3 | Decode class code |
| out_next_mode_o | output | 2 | Mode for the following instruction |
| cur_mode_o | output | 2 | Mode in force for the present window |

## Verification
The length, class and next-mode outputs depend only on the present window and the mode register, so they are due in the same cycle the window is driven. The bench reads them 1 ns after the falling edge on which it drives the inputs. The mode register takes a new value one rising edge after an accepted window or a flush. Each step therefore compares `cur_mode_o` against the previous step's expected next mode, read after the following falling edge. Reset acts asynchronously, so the bench checks it while `rst_n` is still low.

// File: rtl/cmlen_pkg.sv
package cmlen_pkg;

  localparam int HW_W    = 16;
  localparam int EXT_LSB = 10;
  localparam int EXT_W   = 5;
  localparam int MAJ_LSB = 1;
  localparam int MAJ_W   = 3;
  localparam int LO_BIT  = 0;
  localparam int HI_BIT  = 15;

  localparam logic [MAJ_W-1:0] ALT_MAJ = 3'b010;

  typedef enum logic [1:0] {
    MODE_STD = 2'd0,
    MODE_C10 = 2'd1,
    MODE_C16 = 2'd2,
    MODE_ONE = 2'd3
  } mode_e;

  typedef enum logic [2:0] {
    CLS_STD = 3'd0,
    CLS_C10 = 3'd1,
    CLS_C16 = 3'd2,
    CLS_IMM = 3'd3,
    CLS_ALT = 3'd4
  } cls_e;

  typedef struct packed {
    logic             lo_flag;
    logic             hi_flag;
    logic [MAJ_W-1:0] maj;
    logic [EXT_W-1:0] ext;
  } hw_fields_t;

endpackage

// File: rtl/cmlen_fields.sv
module cmlen_fields
  import cmlen_pkg::*;
#(
  parameter int WIN_W = 32
) (
  input  logic [WIN_W-1:0] win_i,
  output hw_fields_t       f_o
);

  localparam int EXTRA_W = WIN_W - HW_W;

  logic [HW_W-1:0] hw;
  assign hw = win_i[HW_W-1:0];

  assign f_o.lo_flag = hw[LO_BIT];
  assign f_o.hi_flag = hw[HI_BIT];
  assign f_o.maj     = hw[MAJ_LSB +: MAJ_W];
  assign f_o.ext     = hw[EXT_LSB +: EXT_W];

  generate
    if (EXTRA_W > 0) begin : g_extra
      logic unused_upper;
      assign unused_upper = ^{win_i[WIN_W-1:HW_W], hw};
    end else begin : g_exact
      logic unused_hw;
      assign unused_hw = ^hw;
    end
  endgenerate

endmodule

// File: rtl/cmlen_decode.sv
module cmlen_decode
  import cmlen_pkg::*;
#(
  parameter logic [EXT_W-1:0] MARKER = 5'b10110
) (
  input  mode_e      mode_i,
  input  hw_fields_t f_i,
  output cls_e       cls_o,
  output logic [2:0] bytes_o,
  output mode_e      nxt_o
);

  localparam logic [2:0] BYTES_HALF = 3'd2;
  localparam logic [2:0] BYTES_FULL = 3'd4;

  always_comb begin
    cls_o   = CLS_STD;
    bytes_o = BYTES_FULL;
    nxt_o   = MODE_STD;
    unique case (mode_i)
      MODE_STD: begin
        if (f_i.ext == MARKER) begin
          cls_o   = CLS_C10;
          bytes_o = BYTES_HALF;
          nxt_o   = MODE_C10;
        end
      end
      MODE_C10: begin
        cls_o   = CLS_C10;
        bytes_o = BYTES_HALF;
        nxt_o   = f_i.hi_flag ? MODE_C16 : MODE_STD;
      end
      MODE_C16: begin
        bytes_o = BYTES_HALF;
        nxt_o   = f_i.hi_flag ? MODE_C16 : MODE_ONE;
        if (f_i.lo_flag && f_i.hi_flag)
          cls_o = CLS_IMM;
        else if (f_i.lo_flag && (f_i.maj == ALT_MAJ))
          cls_o = CLS_ALT;
        else
          cls_o = CLS_C16;
      end
      MODE_ONE: begin
        cls_o   = CLS_STD;
        bytes_o = BYTES_FULL;
        nxt_o   = MODE_C16;
      end
      default: begin
        cls_o   = CLS_STD;
        bytes_o = BYTES_FULL;
        nxt_o   = MODE_STD;
      end
    endcase
  end

endmodule

// File: rtl/cmlen_mode_reg.sv
module cmlen_mode_reg
  import cmlen_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  flush_i,
  input  logic  adv_i,
  input  mode_e nxt_i,
  output mode_e mode_o
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      mode_o <= MODE_STD;
    else if (flush_i)
      mode_o <= MODE_STD;
    else if (adv_i)
      mode_o <= nxt_i;
  end

  AST_FLUSH_STD: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |=> (mode_o == MODE_STD)); // R10

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!flush_i && !adv_i) |=> $stable(mode_o)); // R9

endmodule

// File: rtl/cmlen_top.sv
module cmlen_top
  import cmlen_pkg::*;
#(
  parameter int               WIN_W  = 32,
  parameter logic [EXT_W-1:0] MARKER = 5'b10110
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush_i,
  input  logic             in_valid_i,
  output logic             in_ready_o,
  input  logic [WIN_W-1:0] in_win_i,
  output logic             out_valid_o,
  input  logic             out_ready_i,
  output logic [2:0]       out_bytes_o,
  output logic [2:0]       out_class_o,
  output logic [1:0]       out_next_mode_o,
  output logic [1:0]       cur_mode_o
);

  hw_fields_t fields;
  mode_e      cur_mode;
  mode_e      nxt_mode;
  cls_e       cls;
  logic [2:0] bytes;
  logic       adv;

  assign in_ready_o  = out_ready_i;
  assign out_valid_o = in_valid_i;
  assign adv         = in_valid_i && out_ready_i;

  cmlen_fields #(.WIN_W(WIN_W)) u_fields (
    .win_i (in_win_i),
    .f_o   (fields)
  );

  cmlen_decode #(.MARKER(MARKER)) u_decode (
    .mode_i  (cur_mode),
    .f_i     (fields),
    .cls_o   (cls),
    .bytes_o (bytes),
    .nxt_o   (nxt_mode)
  );

  cmlen_mode_reg u_mode (
    .clk     (clk),
    .rst_n   (rst_n),
    .flush_i (flush_i),
    .adv_i   (adv),
    .nxt_i   (nxt_mode),
    .mode_o  (cur_mode)
  );

  assign out_bytes_o     = bytes;
  assign out_class_o     = cls;
  assign out_next_mode_o = nxt_mode;
  assign cur_mode_o      = cur_mode;

  AST_COMP_LEN16: assert property (@(posedge clk) disable iff (!rst_n)
    ((cur_mode == MODE_C10) || (cur_mode == MODE_C16)) |-> (bytes == 3'd2)); // R4

  AST_ONE_STD: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_mode == MODE_ONE) |-> ((bytes == 3'd4) && (cls == CLS_STD))); // R8

  AST_ONE_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
    ((cur_mode == MODE_ONE) && adv && !flush_i) |=> (cur_mode == MODE_C16)); // R8

  AST_ADV_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !flush_i) |=> (cur_mode == $past(nxt_mode))); // R9

  AST_IMM_STAY: assert property (@(posedge clk) disable iff (!rst_n)
    ((cur_mode == MODE_C16) && (cls == CLS_IMM)) |-> (nxt_mode == MODE_C16)); // R5

endmodule

// File: tb/sim_cmlen_top.sv
module sim_cmlen_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flush = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] win = 32'h0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [2:0]  bytes;
  logic [2:0]  cls;
  logic [1:0]  nxt;
  logic [1:0]  cur;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  cmlen_top u0 (
    .clk             (clk),
    .rst_n           (rst_n),
    .flush_i         (flush),
    .in_valid_i      (in_valid),
    .in_ready_o      (in_ready),
    .in_win_i        (win),
    .out_valid_o     (out_valid),
    .out_ready_i     (out_ready),
    .out_bytes_o     (bytes),
    .out_class_o     (cls),
    .out_next_mode_o (nxt),
    .cur_mode_o      (cur)
  );

  // {window, class, bytes, next mode}; upper window halves vary for R11
  localparam int NV = 14;
  localparam logic [39:0] VEC [0:NV-1] = '{
    {32'h0000_1234, 3'd0, 3'd4, 2'd0},
    {32'hFFFF_5800, 3'd1, 3'd2, 2'd1},
    {32'h1357_0001, 3'd1, 3'd2, 2'd0},
    {32'h0000_D800, 3'd1, 3'd2, 2'd1},
    {32'hAAAA_D801, 3'd1, 3'd2, 2'd2},
    {32'h5555_8001, 3'd3, 3'd2, 2'd2},
    {32'h0F0F_0005, 3'd4, 3'd2, 2'd3},
    {32'h0000_5800, 3'd0, 3'd4, 2'd2},
    {32'hDEAD_8004, 3'd2, 3'd2, 2'd2},
    {32'hBEEF_8005, 3'd3, 3'd2, 2'd2},
    {32'h0000_0004, 3'd2, 3'd2, 2'd3},
    {32'hFFFF_0000, 3'd0, 3'd4, 2'd2},
    {32'h0000_0003, 3'd2, 3'd2, 2'd3},
    {32'h7777_1234, 3'd0, 3'd4, 2'd2}
  };

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic drive(input logic [31:0] w, input logic v, input logic r, input logic f);
    @(negedge clk);
    win = w;
    in_valid = v;
    out_ready = r;
    flush = f;
    #1;
  endtask

  function automatic string req_of(input logic [1:0] pm, input logic [2:0] c);
    if (pm == 2'd3) return "R8";
    if (pm == 2'd1) return "R4";
    if (pm == 2'd0) return (c == 3'd1) ? "R3" : "R2";
    if (c == 3'd3) return "R5";
    if (c == 3'd4) return "R6";
    return "R7";
  endfunction

  initial begin
    logic [1:0] pm;
    string rq;
    repeat (2) @(posedge clk);
    #1;
    check("R1 reset mode", cur, 0);
    @(negedge clk);
    rst_n = 1'b1;

    // table walk, one accepted window per cycle
    pm = 2'd0;
    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][39:8], 1'b1, 1'b1, 1'b0);
      rq = req_of(pm, VEC[i][7:5]);
      check({rq, " mode"}, cur, pm);
      check({rq, " class"}, cls, VEC[i][7:5]);
      check({rq, " bytes"}, bytes, VEC[i][4:2]);
      check({rq, " next"}, nxt, VEC[i][1:0]);
      pm = VEC[i][1:0];
    end

    // R9: stall with ready low, mode is compressed-16 here
    drive(32'h0000_0004, 1'b1, 1'b0, 1'b0);
    check("R9 mode before stall", cur, 2);
    check("R9 in_ready", in_ready, 0);
    check("R9 out_valid", out_valid, 1);
    check("R7 next shown while stalled", nxt, 3);
    drive(32'h0000_0004, 1'b0, 1'b1, 1'b0);
    check("R9 mode held ready low", cur, 2);
    check("R9 out_valid low", out_valid, 0);
    check("R9 in_ready high", in_ready, 1);
    drive(32'h0000_0004, 1'b1, 1'b1, 1'b0);
    check("R9 mode held valid low", cur, 2);
    drive(32'h0000_1234, 1'b0, 1'b0, 1'b0);
    check("R9 mode after handshake", cur, 3);

    // R10: flush overrides handshake
    drive(32'h0000_1234, 1'b1, 1'b1, 1'b1);
    drive(32'h0000_1234, 1'b0, 1'b0, 1'b0);
    check("R10 flush to standard", cur, 0);

    // R11: upper bits cannot create a marker
    drive(32'h5800_1234, 1'b1, 1'b1, 1'b0);
    check("R11 class", cls, 0);
    check("R11 bytes", bytes, 4);
    check("R11 next", nxt, 0);

    // R6: alternate with hi flag set selects IMM (R5 priority) but hi clear gives ALT
    drive(32'h0000_5800, 1'b1, 1'b1, 1'b0);
    drive(32'h0000_8000, 1'b1, 1'b1, 1'b0);
    check("R4 next c16", nxt, 2);
    drive(32'h0000_0005, 1'b1, 1'b1, 1'b0);
    check("R6 class", cls, 4);
    check("R6 next", nxt, 3);
    drive(32'h0000_5800, 1'b1, 1'b1, 1'b0);
    check("R8 marker ignored", cls, 0);
    check("R8 bytes", bytes, 4);

    // R10: flush without handshake
    drive(32'h0000_0000, 1'b0, 1'b0, 1'b1);
    drive(32'h0000_0000, 1'b0, 1'b0, 1'b0);
    check("R10 flush idle", cur, 0);

    // R1: asynchronous reset from compressed-10
    drive(32'h0000_5800, 1'b1, 1'b1, 1'b0);
    drive(32'h0000_0000, 1'b0, 1'b0, 1'b0);
    check("R3 entered c10", cur, 1);
    rst_n = 1'b0;
    #1;
    check("R1 async reset", cur, 0);
    @(negedge clk);
    rst_n = 1'b1;
    drive(32'h0000_0000, 1'b0, 1'b0, 1'b0);
    check("R1 stays standard", cur, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule